// File: doc/BRIEF.md
# SPI Burst Exchange Engine

The engine is the serial side of an SPI master that moves a whole burst of 8-bit words without help. Software programs a control word, a 24-bit total burst length and a 24-bit transmit length. It then sets the go bit. From that point the engine runs every word of the burst. It takes transmit bytes from an upstream stream and hands received bytes to a downstream stream. It toggles the serial clock once per `sclk_tick` pulse and drives up to four chip-select lines. Once the last word has been shifted, it signals completion.

The total length and the transmit length are counted separately. When the transmit length runs out before the burst ends, the remaining words go out as zero bytes and no further data is taken from the transmit stream. A discard bit stops received words from being handed on, which suits transmit-only bursts. A polarity bit sets the asserted level of the chip selects and also sets the level held on every line that is not asserted.

Both data interfaces use valid/ready handshakes, and the engine applies back-pressure only at word boundaries. A transmit byte is taken in the cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is never raised without `tx_valid`. A received byte waits in a holding register with `rx_valid` high and `rx_data` stable until `rx_ready` accepts it. No new word starts while that register is full, unless discard is set. If the transmit stream is empty, the engine waits with the serial clock at its idle level. It does not shift a partial word.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset the control word reads 0, all chip-select lines, `sclk`, `done`, `tx_ready` and `rx_valid` are 0.
- R2: A write that sets the go bit (bit 10) is honoured only if the same write also sets the enable bit (bit 0) and the master bit (bit 1); otherwise bit 10 reads back 0 and no clock edge occurs.
- R3: With no burst running, `sclk` equals control bit 3 (clock polarity). Bit 2 (clock phase) set: data changes on the leading edge and is sampled on the trailing edge. Bit 2 clear: the first bit is presented before the first edge, sampling is on leading edges and changes are on trailing edges.
- R4: Control bit 6 set shifts each word least significant bit first; clear shifts most significant bit first. The same order applies to both `mosi` and `miso`.
- R5: A burst shifts exactly `burst_len` words (16 `sclk` transitions each). It takes exactly min(`tx_len`, `burst_len`) bytes from the transmit stream, and `tx_ready` is high only while `tx_valid` is high.
- R6: Words after the transmit length is exhausted are sent as 0x00.
- R7: With control bit 15 set, no received word is presented on the receive stream.
- R8: Each received word is offered on `rx_data` with `rx_valid`, held stable until accepted, and the next word does not start while it waits.
- R9: When the burst ends, `done` pulses for one cycle and bit 10 reads 0 in that same cycle. A burst length of 0 completes with no clock edge.
- R10: In automatic mode (bit 16 clear), the line chosen by bits 13:12 is at its asserted level from the go cycle until completion. All other lines, and the chosen line outside a burst, sit at the idle level.
- R11: With bit 16 set, the chosen line is driven to the value of bit 17 regardless of burst activity. The other lines stay at the idle level.
- R12: Bit 4 set makes the asserted level 0 and the idle level 1; bit 4 clear makes the asserted level 1 and the idle level 0. At most one line ever differs from the idle level.
- R13: While transmit bytes remain but `tx_valid` is low, the engine waits between words with `sclk` at its idle level. The burst stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| ctrl_rdata | output | 32 | Current control word; bit 10 shows the burst in progress |
| burst_len | input | 24 | Words in the burst, sampled when the burst begins |
| tx_len | input | 24 | Words taken from the transmit stream, sampled when the burst begins |
| sclk_tick | input | 1 | One pulse per half serial-clock period |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Transmit byte taken this cycle |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Downstream accepts received byte |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines |
| done | output | 1 | One-cycle burst completion pulse |

## Verification
The serial lines are looped back inverted, so every received word must be the complement of the word sent. This separates correct sample timing from sampling on the wrong edge in each of the four clock modes. Asymmetric bytes sent in both bit orders tell a reversed shifter apart from a correct one. Bursts longer than their transmit length show zero-fill and the pop count. Zero-length bursts, a starved transmit stream and a blocked receive stream exercise the three ways a burst can end or pause at a word boundary. Chip-select patterns under both polarities, in automatic and manual modes, confirm the asserted level and the idle level.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  // control word bit positions
  localparam int CB_EN     = 0;
  localparam int CB_MST    = 1;
  localparam int CB_CPHA   = 2;
  localparam int CB_CPOL   = 3;
  localparam int CB_CSLOW  = 4;
  localparam int CB_LSB    = 6;
  localparam int CB_GO     = 10;
  localparam int CB_SEL_LO = 12;
  localparam int CB_DROP   = 15;
  localparam int CB_CSMAN  = 16;
  localparam int CB_CSLVL  = 17;
  localparam logic [31:0] CTRL_MASK = 32'h0003_B45F;

  typedef enum logic [1:0] {
    BS_IDLE  = 2'd0,
    BS_FETCH = 2'd1,
    BS_SHIFT = 2'd2
  } burst_state_t;

  typedef struct packed {
    logic en;
    logic master;
    logic cpha;
    logic cpol;
    logic cs_low;
    logic lsb;
    logic drop;
    logic cs_man;
    logic cs_lvl;
  } spi_cfg_t;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] byte_i,
  input  logic         cpol_i,
  input  logic         cpha_i,
  input  logic         lsb_i,
  input  logic         tick_i,
  input  logic         miso_i,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int NEDGE = 2 * W;
  localparam int EW    = $clog2(NEDGE);
  localparam logic [EW-1:0] LAST = EW'(NEDGE - 1);
  localparam logic [EW-1:0] FIRST = '0;

  logic [EW-1:0] edge_q;
  logic [W-1:0]  out_sh, in_sh, in_next, rx_q;
  logic          sclk_q, busy_q, done_q;
  logic          odd, samp, adv;

  assign odd  = edge_q[0];
  // phase 0: sample on leading (even) edges, change on trailing ones
  // phase 1: change on leading edges after the first, sample on trailing ones
  assign samp = cpha_i ? odd : ~odd;
  assign adv  = cpha_i ? (~odd && (edge_q != FIRST)) : (odd && (edge_q != LAST));
  assign in_next = lsb_i ? {miso_i, in_sh[W-1:1]} : {in_sh[W-2:0], miso_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      out_sh <= '0;
      in_sh  <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        out_sh <= byte_i;
        in_sh  <= '0;
        sclk_q <= cpol_i;
      end else if (busy_q && tick_i) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (samp) in_sh <= in_next;
        if (adv) out_sh <= lsb_i ? (out_sh >> 1) : (out_sh << 1);
        if (edge_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= samp ? in_next : in_sh;
        end
      end
    end
  end

  assign sclk_o = busy_q ? sclk_q : cpol_i;
  assign mosi_o = lsb_i ? out_sh[0] : out_sh[W-1];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NCS = 4,
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [SW-1:0]  sel_i,
  input  logic           act_low_i,
  input  logic           manual_i,
  input  logic           man_lvl_i,
  input  logic           busy_i,
  output logic [NCS-1:0] cs_o
);
  logic idle_lvl;
  assign idle_lvl = act_low_i;

  for (genvar i = 0; i < NCS; i++) begin : g_line
    always_comb begin
      if (sel_i != SW'(i))
        cs_o[i] = idle_lvl;
      else if (manual_i)
        cs_o[i] = man_lvl_i;
      else
        cs_o[i] = busy_i ? ~idle_lvl : idle_lvl;
    end
  end
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_burst_pkg::*;
#(
  parameter int W    = 8,
  parameter int CW   = 24,
  parameter int NCS  = 4,
  localparam int SW  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [31:0]   ctrl_wdata,
  output logic [31:0]   ctrl_rdata,
  input  logic [CW-1:0] burst_len,
  input  logic [CW-1:0] tx_len,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [W-1:0]  tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [W-1:0]  rx_data,
  output logic          sh_load,
  output logic [W-1:0]  sh_byte,
  input  logic          sh_done,
  input  logic [W-1:0]  sh_rx,
  output logic          busy_o,
  output logic          done_o,
  output logic          cpol_o,
  output logic          cpha_o,
  output logic          lsb_o,
  output logic          cs_low_o,
  output logic          cs_man_o,
  output logic          cs_lvl_o,
  output logic [SW-1:0] sel_o
);
  burst_state_t  state_q;
  logic [31:0]   ctrl_q;
  logic [CW-1:0] burst_left, tx_left;
  logic          rx_valid_q, done_q;
  logic [W-1:0]  rx_data_q;
  spi_cfg_t      cfg;
  logic          tx_need, rx_ok, can_go, finish, busy, go_ok;

  always_comb begin
    cfg.en     = ctrl_q[CB_EN];
    cfg.master = ctrl_q[CB_MST];
    cfg.cpha   = ctrl_q[CB_CPHA];
    cfg.cpol   = ctrl_q[CB_CPOL];
    cfg.cs_low = ctrl_q[CB_CSLOW];
    cfg.lsb    = ctrl_q[CB_LSB];
    cfg.drop   = ctrl_q[CB_DROP];
    cfg.cs_man = ctrl_q[CB_CSMAN];
    cfg.cs_lvl = ctrl_q[CB_CSLVL];
  end

  assign busy    = (state_q != BS_IDLE);
  assign tx_need = (tx_left != '0);
  assign rx_ok   = cfg.drop || !rx_valid_q;
  assign can_go  = (state_q == BS_FETCH) && (burst_left != '0)
                   && (!tx_need || tx_valid) && rx_ok;
  assign finish  = (state_q == BS_FETCH) && (burst_left == '0);
  assign go_ok   = ctrl_wdata[CB_GO] && ctrl_wdata[CB_EN] && ctrl_wdata[CB_MST];

  assign tx_ready = can_go && tx_need;
  assign sh_load  = can_go;
  assign sh_byte  = tx_need ? tx_data : '0;

  // control word; go bit is owned here and self-clears at completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata & CTRL_MASK;
      if (finish)
        ctrl_q[CB_GO] <= 1'b0;
      else if (ctrl_we)
        ctrl_q[CB_GO] <= busy | go_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= BS_IDLE;
      burst_left <= '0;
      tx_left    <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        BS_IDLE: begin
          if (ctrl_q[CB_GO]) begin
            burst_left <= burst_len;
            tx_left    <= tx_len;
            state_q    <= BS_FETCH;
          end
        end
        BS_FETCH: begin
          if (finish) begin
            done_q  <= 1'b1;
            state_q <= BS_IDLE;
          end else if (can_go) begin
            burst_left <= burst_left - 1'b1;
            if (tx_need) tx_left <= tx_left - 1'b1;
            state_q <= BS_SHIFT;
          end
        end
        BS_SHIFT: begin
          if (sh_done) state_q <= BS_FETCH;
        end
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  // receive holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else if (sh_done && !cfg.drop) begin
      rx_valid_q <= 1'b1;
      rx_data_q  <= sh_rx;
    end else if (rx_ready) begin
      rx_valid_q <= 1'b0;
    end
  end

  assign ctrl_rdata = ctrl_q;
  assign rx_valid   = rx_valid_q;
  assign rx_data    = rx_data_q;
  assign busy_o     = busy;
  assign done_o     = done_q;
  assign cpol_o     = cfg.cpol;
  assign cpha_o     = cfg.cpha;
  assign lsb_o      = cfg.lsb;
  assign cs_low_o   = cfg.cs_low;
  assign cs_man_o   = cfg.cs_man;
  assign cs_lvl_o   = cfg.cs_lvl;
  assign sel_o      = ctrl_q[CB_SEL_LO +: SW];
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 24,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [31:0]       ctrl_wdata,
  output logic [31:0]       ctrl_rdata,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              sclk_tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_line,
  output logic              done
);
  localparam int SW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic              sh_load, sh_done, sh_busy, busy;
  logic [WORD_W-1:0] sh_byte, sh_rx;
  logic              cpol, cpha, lsb, cs_low, cs_man, cs_lvl;
  logic [SW-1:0]     sel;

  spi_burst_seq #(.W(WORD_W), .CW(CNT_W), .NCS(NUM_CS)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .burst_len(burst_len), .tx_len(tx_len),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sh_load(sh_load), .sh_byte(sh_byte), .sh_done(sh_done), .sh_rx(sh_rx),
    .busy_o(busy), .done_o(done),
    .cpol_o(cpol), .cpha_o(cpha), .lsb_o(lsb),
    .cs_low_o(cs_low), .cs_man_o(cs_man), .cs_lvl_o(cs_lvl), .sel_o(sel)
  );

  spi_byte_shifter #(.W(WORD_W)) i_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(sh_load), .byte_i(sh_byte),
    .cpol_i(cpol), .cpha_i(cpha), .lsb_i(lsb),
    .tick_i(sclk_tick), .miso_i(miso),
    .sclk_o(sclk), .mosi_o(mosi), .busy_o(sh_busy),
    .done_o(sh_done), .rx_o(sh_rx)
  );

  spi_cs_drive #(.NCS(NUM_CS)) i_cs (
    .sel_i(sel), .act_low_i(cs_low), .manual_i(cs_man),
    .man_lvl_i(cs_lvl), .busy_i(busy | sh_busy), .cs_o(cs_line)
  );
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk #(
  parameter int WORD_W = 8,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       ctrl_rdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_line,
  input logic              done
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctrl_rdata[10]);
  // R3
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[10] |-> (sclk == ctrl_rdata[3]));
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R7
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_rdata[15]) |-> !$rose(rx_valid));
  // R12
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_rdata[4] ? ~cs_line : cs_line));
  // R5
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_valid);
endmodule

bind spi_burst_engine spi_burst_chk #(.WORD_W(WORD_W), .NUM_CS(NUM_CS)) i_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_rdata(ctrl_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .sclk(sclk), .cs_line(cs_line), .done(done)
);

// File: tb/test_spi_burst_engine.sv
module test_spi_burst_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic [23:0] burst_len = '0, tx_len = '0;
  logic        sclk_tick = 1'b0;
  logic        tx_valid, tx_ready, rx_valid;
  logic        rx_ready = 1'b1;
  logic [7:0]  tx_data, rx_data;
  logic        sclk, mosi, miso, done;
  logic [3:0]  cs_line;

  int n_chk = 0, n_err = 0;
  logic [7:0] tx_mem [0:15];
  logic [7:0] rx_mem [0:15];
  logic [7:0] cap    [0:15];
  int tx_ptr = 0, tx_avail = 0, rx_n = 0, done_n = 0;
  int edges = 0, cap_n = 0, nb = 0;
  logic [7:0] cur = '0;
  logic sclk_prev = 1'b0, cpol_m = 1'b0, cpha_m = 1'b0, lsb_m = 1'b0;

  always #4 clk = ~clk;

  spi_burst_engine i_spi_burst_engine (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .burst_len(burst_len), .tx_len(tx_len),
    .sclk_tick(sclk_tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_line(cs_line), .done(done)
  );

  // inverted loopback: every received word is the complement of the sent word
  assign miso     = ~mosi;
  assign tx_valid = (tx_ptr < tx_avail);
  assign tx_data  = tx_mem[tx_ptr[3:0]];

  always @(negedge clk) sclk_tick <= ~sclk_tick;

  always @(posedge clk) begin
    if (tx_valid && tx_ready) tx_ptr <= tx_ptr + 1;
    if (rx_valid && rx_ready) begin
      rx_mem[rx_n[3:0]] <= rx_data;
      rx_n <= rx_n + 1;
    end
    if (done) done_n <= done_n + 1;
  end

  // serial monitor: capture mosi on the sampling edge of the current mode
  always @(negedge clk) begin
    if (rst_n && (sclk !== sclk_prev)) begin
      edges = edges + 1;
      if (cpha_m ? (sclk_prev != cpol_m) : (sclk_prev == cpol_m)) begin
        cur = lsb_m ? {mosi, cur[7:1]} : {cur[6:0], mosi};
        nb = nb + 1;
        if (nb == 8) begin
          cap[cap_n[3:0]] = cur;
          cap_n = cap_n + 1;
          nb = 0;
        end
      end
    end
    sclk_prev = sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // control word: en(0) master(1) cpha(2) cpol(3) cslow(4) lsb(6) go(10)
  // sel(13:12) drop(15) manual(16) level(17)
  function automatic logic [31:0] mk(input bit cpol, input bit cpha, input bit lsb,
                                     input bit cslow, input bit drop, input int sel);
    return 32'h3 | (32'(cpha) << 2) | (32'(cpol) << 3) | (32'(cslow) << 4)
           | (32'(lsb) << 6) | (32'(drop) << 15) | ((32'(sel) & 3) << 12);
  endfunction

  task automatic wr(input logic [31:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    step(1);
    ctrl_we = 1'b0;
  endtask

  task automatic begin_burst(input logic [31:0] cfg, input int nb_total, input int ntx);
    burst_len = 24'(nb_total); tx_len = 24'(ntx);
    cpol_m = cfg[3]; cpha_m = cfg[2]; lsb_m = cfg[6];
    wr(cfg);
    step(2);
    edges = 0; cap_n = 0; nb = 0; rx_n = 0; tx_ptr = 0;
    wr(cfg | 32'h400);
  endtask

  task automatic wait_done(input string req, input int limit);
    int start_n = done_n;
    for (int i = 0; i < limit && done_n == start_n; i++) step(1);
    chk({req, " done seen"}, 32'(done_n - start_n), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_rdata, 32'h0);
    chk("R1 cs", 32'(cs_line), 32'h0);
    chk("R1 sclk", 32'(sclk), 32'h0);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 tx_ready", 32'(tx_ready), 32'h0);
    chk("R1 rx_valid", 32'(rx_valid), 32'h0);
  endtask

  task automatic t_mode0();
    tx_mem[0] = 8'hA5; tx_mem[1] = 8'h3C; tx_mem[2] = 8'h81; tx_avail = 3;
    begin_burst(mk(0, 0, 0, 1, 0, 1), 3, 3);
    step(3);
    chk("R10 R12 cs asserted low on line 1", 32'(cs_line), 32'hD);
    wait_done("R9", 400);
    chk("R9 go cleared", 32'(ctrl_rdata[10]), 32'h0);
    chk("R5 edges", 32'(edges), 32'd48);
    chk("R5 pops", 32'(tx_ptr), 32'd3);
    chk("R3 mode0 byte0", 32'(cap[0]), 32'hA5);
    chk("R3 mode0 byte2", 32'(cap[2]), 32'h81);
    chk("R8 rx count", 32'(rx_n), 32'd3);
    chk("R8 rx byte1", 32'(rx_mem[1]), 32'hC3);
    chk("R12 idle high after burst", 32'(cs_line), 32'hF);
  endtask

  task automatic t_mode3_lsb();
    tx_mem[0] = 8'h01; tx_mem[1] = 8'hC8; tx_mem[2] = 8'h55; tx_mem[3] = 8'h77;
    tx_avail = 4;
    begin_burst(mk(1, 1, 1, 0, 0, 0), 4, 2);
    step(3);
    chk("R10 cs asserted high on line 0", 32'(cs_line), 32'h1);
    wait_done("R9", 400);
    chk("R4 lsb byte0", 32'(cap[0]), 32'h01);
    chk("R4 lsb byte1", 32'(cap[1]), 32'hC8);
    chk("R6 zero fill byte2", 32'(cap[2]), 32'h00);
    chk("R6 zero fill byte3", 32'(cap[3]), 32'h00);
    chk("R5 pops limited by tx_len", 32'(tx_ptr), 32'd2);
    chk("R5 edges", 32'(edges), 32'd64);
    chk("R4 rx byte1", 32'(rx_mem[1]), 32'h37);
    chk("R6 rx byte3", 32'(rx_mem[3]), 32'hFF);
    chk("R3 sclk idle high", 32'(sclk), 32'h1);
    chk("R10 cs idle", 32'(cs_line), 32'h0);
  endtask

  task automatic t_discard();
    tx_mem[0] = 8'h12; tx_mem[1] = 8'h34; tx_avail = 2;
    rx_ready = 1'b0;
    begin_burst(mk(0, 1, 0, 0, 1, 2), 2, 2);
    wait_done("R9", 400);
    chk("R7 no rx valid", 32'(rx_valid), 32'h0);
    chk("R7 no rx taken", 32'(rx_n), 32'h0);
    chk("R3 mode1 byte1", 32'(cap[1]), 32'h34);
    rx_ready = 1'b1;
  endtask

  task automatic t_no_enable();
    int d0 = done_n;
    edges = 0;
    wr(32'h0000_0400);
    step(20);
    chk("R2 go dropped without enable", 32'(ctrl_rdata[10]), 32'h0);
    wr(32'h0000_0401);
    step(20);
    chk("R2 go dropped without master", 32'(ctrl_rdata[10]), 32'h0);
    chk("R2 no edges", 32'(edges), 32'h0);
    chk("R2 no done", 32'(done_n - d0), 32'h0);
  endtask

  task automatic t_zero();
    begin_burst(mk(0, 0, 0, 0, 0, 0), 0, 0);
    wait_done("R9 zero length", 10);
    chk("R9 zero length edges", 32'(edges), 32'h0);
  endtask

  task automatic t_stall();
    int d0;
    tx_mem[0] = 8'h6B; tx_mem[1] = 8'hE2; tx_avail = 1;
    begin_burst(mk(1, 0, 0, 1, 0, 3), 2, 2);
    d0 = done_n;
    step(150);
    chk("R13 one word only", 32'(edges), 32'd16);
    chk("R13 sclk idle high", 32'(sclk), 32'h1);
    chk("R13 burst open", 32'(ctrl_rdata[10]), 32'h1);
    chk("R13 cs held", 32'(cs_line), 32'h7);
    chk("R13 no done", 32'(done_n - d0), 32'h0);
    tx_avail = 2;
    wait_done("R13", 400);
    chk("R13 resumed byte", 32'(cap[1]), 32'hE2);
  endtask

  task automatic t_backpressure();
    tx_mem[0] = 8'h4D; tx_mem[1] = 8'h90; tx_avail = 2;
    rx_ready = 1'b0;
    begin_burst(mk(0, 0, 0, 0, 0, 0), 2, 2);
    step(150);
    chk("R8 held valid", 32'(rx_valid), 32'h1);
    chk("R8 held data", 32'(rx_data), 32'hB2);
    chk("R8 next word waits", 32'(edges), 32'd16);
    rx_ready = 1'b1;
    wait_done("R8", 400);
    step(4);
    chk("R8 both taken", 32'(rx_n), 32'd2);
    chk("R8 second word", 32'(rx_mem[1]), 32'h6F);
  endtask

  task automatic t_manual();
    wr(32'h0003_2003);
    step(2);
    chk("R11 manual high line 2", 32'(cs_line), 32'h4);
    wr(32'h0001_2003);
    step(2);
    chk("R11 manual low line 2", 32'(cs_line), 32'h0);
    wr(32'h0001_3013);
    step(2);
    chk("R11 R12 manual low line 3, others high", 32'(cs_line), 32'h7);
    wr(32'h0003_3013);
    step(2);
    chk("R11 manual high line 3", 32'(cs_line), 32'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_mode0();
    t_mode3_lsb();
    t_discard();
    t_no_enable();
    t_zero();
    t_stall();
    t_backpressure();
    t_manual();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule